// File: doc/BRIEF.md
# Edge-Triggered Interrupt Aggregator

This block merges nine level-type event sources into a single interrupt request for a host processor. The sources are two FIFO fill-threshold flags, three timer overflow flags and four external input lines; the logic that produces those levels lives elsewhere. Each source is first brought into the block clock domain through a synchronizer. A status bit is then latched only when that source goes from inactive to active while its enable bit is set. A level that simply stays high never raises a second request.

The host shares one address between a write-only enable register and a read-only status register. A read strobe returns the current status and clears every bit that was set at that moment. An edge that lands in the same cycle as the read is kept for the next read. Several sources may be latched together behind one request. A status read of all zeros tells the host that this block did not raise the interrupt.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the status word reads 0x0000, `irq` is low and every enable bit is clear.
- R2: Status bit positions are fixed: bit 0 is FIFO fill above one half, bit 1 is FIFO fill above three quarters, bits 2, 3, 4 are overflows of timers 1, 2, 3, and bits 5 to 8 are external inputs 1 to 4. The same index of `src_lvl` feeds each bit. A rise of an enabled source, driven between two clock edges, shows in the status on the third following rising clock edge.
- R3: A source edge seen while its enable bit is clear sets nothing. Setting the enable bit later, while the source is still high, also sets nothing.
- R4: A source held high sets its bit once only. A falling source level sets nothing.
- R5: Sources that rise together are all latched into the same status word, and one read returns them.
- R6: A read (`st_rd` high for one cycle) returns the status and clears the bits it returned. An enabled edge that is latched on that same clock edge survives and appears on the next read.
- R7: `irq` is high exactly when any status bit is set, and it stays high with no read until a read clears the bits.
- R8: Status bits 15 to 9 always read 0, and enable write bits 15 to 9 have no effect.
- R9: When no enabled source has risen since the last read, a read returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | 9 | Raw source levels, active high, bit order as in R2 |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 16 | Enable write data, bit n enables status bit n |
| st_rd | input | 1 | Read strobe for the status register; clears the bits returned |
| st_rdata | output | 16 | Current status word |
| irq | output | 1 | Interrupt request to the host |

## Verification
Two functions can fall in the same cycle: the read-to-clear of the status word and the latching of a new source edge. The bench lines them up by raising one source exactly two clock edges before a read strobe. The third edge, which sets the new bit, is then the edge that performs the read. The scoreboard expects the read to return only the older bit and the next read to return the new bit alone. A second collision, where several sources rise in one cycle, is judged by requiring every bit to be present in one word.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int unsigned IRQ_SRC_N   = 9;
   localparam int unsigned IRQ_WORD_W  = 16;
   localparam int unsigned IRQ_SYNC_N  = 2;

   // Fixed bit positions of the status word.
   localparam int unsigned BIT_FILL_HALF  = 0;
   localparam int unsigned BIT_FILL_3Q    = 1;
   localparam int unsigned BIT_TMR_FIRST  = 2;
   localparam int unsigned BIT_TMR_COUNT  = 3;
   localparam int unsigned BIT_EXT_FIRST  = 5;
   localparam int unsigned BIT_EXT_COUNT  = 4;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int unsigned WIDTH  = 9,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);
   logic [WIDTH-1:0] stg_q [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("irq_sync: at least two stages required");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[0] <= '0;
               else        stg_q[0] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[s] <= '0;
               else        stg_q[s] <= stg_q[s-1];
            end
         end
      end
   endgenerate

   assign d_out = stg_q[STAGES-1];
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
   parameter int unsigned WIDTH = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] rise
);
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign rise[i] = lvl[i] & ~prev_q[i];
      end
   endgenerate
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
   parameter int unsigned NSRC   = 9,
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   rise,
   input  logic              en_wr,
   input  logic [WORD_W-1:0] en_wdata,
   input  logic              st_rd,
   output logic [WORD_W-1:0] st_word,
   output logic              any_set
);
   localparam int unsigned PAD_W = WORD_W - NSRC;

   logic [NSRC-1:0] en_q;
   logic [NSRC-1:0] stat_q;
   logic [NSRC-1:0] stat_keep;
   logic [NSRC-1:0] stat_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= '0;
      else if (en_wr) en_q <= en_wdata[NSRC-1:0];
   end

   always_comb begin
      stat_keep = st_rd ? '0 : stat_q;
      stat_d    = stat_keep | (rise & en_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_d;
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign st_word = {{PAD_W{1'b0}}, stat_q};
      end else begin : g_nopad
         assign st_word = stat_q;
      end
   endgenerate

   assign any_set = |stat_q;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
   import irq_pkg::*;
#(
   parameter int unsigned NUM_SRC     = IRQ_SRC_N,
   parameter int unsigned WORD_W      = IRQ_WORD_W,
   parameter int unsigned SYNC_STAGES = IRQ_SYNC_N
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_lvl,
   input  logic               en_wr,
   input  logic [WORD_W-1:0]  en_wdata,
   input  logic               st_rd,
   output logic [WORD_W-1:0]  st_rdata,
   output logic               irq
);
   generate
      if (NUM_SRC > WORD_W) begin : g_bad_width
         $error("irq_aggregator: more sources than status bits");
      end
      if (NUM_SRC == 0) begin : g_bad_count
         $error("irq_aggregator: no sources");
      end
   endgenerate

   logic [NUM_SRC-1:0] lvl_sync;
   logic [NUM_SRC-1:0] lvl_rise;

   irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (src_lvl),
      .d_out (lvl_sync)
   );

   irq_edge_det #(.WIDTH(NUM_SRC)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (lvl_sync),
      .rise  (lvl_rise)
   );

   irq_status_reg #(.NSRC(NUM_SRC), .WORD_W(WORD_W)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise     (lvl_rise),
      .en_wr    (en_wr),
      .en_wdata (en_wdata),
      .st_rd    (st_rd),
      .st_word  (st_rdata),
      .any_set  (irq)
   );
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
   parameter int unsigned NUM_SRC = 9,
   parameter int unsigned WORD_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en_wr,
   input logic [WORD_W-1:0] en_wdata,
   input logic              st_rd,
   input logic [WORD_W-1:0] st_rdata,
   input logic              irq
);
   localparam logic [WORD_W-1:0] LIVE_MASK = WORD_W'((64'd1 << NUM_SRC) - 64'd1);

   logic [WORD_W-1:0] en_shadow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_shadow <= '0;
      else if (en_wr) en_shadow <= en_wdata & LIVE_MASK;
   end

   AST_IRQ_IS_ANY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (st_rdata != '0)); // R7

   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (st_rdata & ~LIVE_MASK) == '0); // R8

   AST_BITS_HELD_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !st_rd |=> ((st_rdata & $past(st_rdata)) == $past(st_rdata))); // R7

   AST_NEW_BIT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (st_rdata & ~($past(st_rd) ? '0 : $past(st_rdata)) & ~$past(en_shadow)) == '0); // R3
endmodule

bind irq_aggregator irq_aggregator_chk #(.NUM_SRC(NUM_SRC), .WORD_W(WORD_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en_wr    (en_wr),
   .en_wdata (en_wdata),
   .st_rd    (st_rd),
   .st_rdata (st_rdata),
   .irq      (irq)
);

// File: tb/irq_aggregator_bench.sv
`timescale 1ns/1ps
module irq_aggregator_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [8:0]  src_lvl = '0;
   logic        en_wr = 1'b0;
   logic [15:0] en_wdata = '0;
   logic        st_rd = 1'b0;
   logic [15:0] st_rdata;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [15:0] exp_q [$];
   string       tag_q [$];

   always #5 clk = ~clk;

   irq_aggregator u_irq_aggregator (
      .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .en_wr(en_wr),
      .en_wdata(en_wdata), .st_rd(st_rd), .st_rdata(st_rdata), .irq(irq)
   );

   task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
      end
   endtask

   // All tasks start right after a falling edge and end after one.
   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_irq(input logic exp, input string tag);
      #1;
      check({15'd0, irq}, {15'd0, exp}, tag);
   endtask

   task automatic write_en(input logic [15:0] v);
      en_wr = 1'b1; en_wdata = v;
      tick(1);
      en_wr = 1'b0; en_wdata = '0;
   endtask

   task automatic do_read(input logic [15:0] exp, input string tag);
      st_rd = 1'b1;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      tick(1);
      st_rd = 1'b0;
   endtask

   // Monitor: compares each read against the scoreboard queue.
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (st_rd) begin
            if (exp_q.size() == 0) begin
               check(st_rdata, 16'hxxxx, "scoreboard empty");
            end else begin
               logic [15:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(st_rdata, e, t);
            end
         end
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      tick(3);
      check_irq(1'b0, "R1 irq low in reset");
      rst_n = 1'b1;
      tick(2);
      check_irq(1'b0, "R1 irq low after reset");
      // R1: enables clear after reset, so an edge sets nothing
      src_lvl[0] = 1'b1;
      tick(5);
      do_read(16'h0000, "R1 enables clear after reset");
      src_lvl = '0;
      tick(3);
      do_read(16'h0000, "R9 idle read is zero");

      write_en(16'h01FF);
      tick(3);
      // R2: latency of three rising edges
      src_lvl[0] = 1'b1;
      tick(2);
      check_irq(1'b0, "R2 not yet after two edges");
      tick(1);
      check_irq(1'b1, "R2 set on third edge");
      do_read(16'h0001, "R2 bit0 fill half");
      check_irq(1'b0, "R6 irq cleared by read");
      tick(5);
      do_read(16'h0000, "R4 held level sets once");
      src_lvl[0] = 1'b0;
      tick(5);
      do_read(16'h0000, "R4 falling edge ignored");

      // R2: every other bit position individually
      for (int b = 1; b < 9; b++) begin
         src_lvl[b] = 1'b1;
         tick(4);
         do_read(16'(1 << b), "R2 bit position");
         src_lvl[b] = 1'b0;
         tick(3);
      end

      // R3: disabled source
      write_en(16'h01DF);
      src_lvl[5] = 1'b1;
      tick(5);
      do_read(16'h0000, "R3 disabled edge ignored");
      write_en(16'h01FF);
      tick(4);
      do_read(16'h0000, "R3 late enable no set");
      src_lvl[5] = 1'b0;
      tick(4);

      // R5: simultaneous sources
      src_lvl[2] = 1'b1; src_lvl[4] = 1'b1; src_lvl[8] = 1'b1;
      tick(4);
      check_irq(1'b1, "R5 irq on group");
      do_read(16'h0114, "R5 three bits in one word");
      src_lvl = '0;
      tick(4);

      // R7: irq held without a read
      src_lvl[1] = 1'b1;
      tick(4);
      tick(10);
      check_irq(1'b1, "R7 irq held");
      do_read(16'h0002, "R7 bit1 still set");
      src_lvl = '0;
      tick(4);

      // R6: read collides with a new edge
      src_lvl[6] = 1'b1;
      tick(5);
      src_lvl[3] = 1'b1;
      tick(2);
      do_read(16'h0040, "R6 read at collision edge");
      check_irq(1'b1, "R6 new edge survives read");
      do_read(16'h0008, "R6 kept edge on next read");
      src_lvl = '0;
      tick(4);

      // R8: reserved enable bits have no effect
      write_en(16'hFE00);
      src_lvl[7] = 1'b1;
      tick(5);
      do_read(16'h0000, "R8 reserved enables do nothing");
      src_lvl[7] = 1'b0;
      write_en(16'hFFFF);
      tick(3);
      src_lvl[7] = 1'b1;
      tick(4);
      do_read(16'h0080, "R8 upper bits read zero");
      src_lvl = '0;
      tick(4);

      // R1: reset in the middle of a pending request
      src_lvl[0] = 1'b1;
      tick(4);
      check_irq(1'b1, "R1 pending before reset");
      rst_n = 1'b0;
      tick(1);
      check_irq(1'b0, "R1 reset clears irq");
      src_lvl = '0;
      rst_n = 1'b1;
      tick(3);
      src_lvl[1] = 1'b1;
      tick(5);
      do_read(16'h0000, "R1 reset clears enables");

      tick(3);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule